// File: doc/BRIEF.md
# Multi-Mode Boost Converter Switch Controller

This block makes every switching decision for a synchronous boost converter. Once per switching period it may start a pulse. A pulse is a low-side on interval, a dead gap, a rectifier interval, a second dead gap, and one decision cycle. Comparator results reach the block as digital flags: output below target, output below the lower window border, output above the upper window border, and inductor current limit. The block drives the two gate enables and reports its operating level.

Operation climbs a ladder of four levels. Levels 0 to 2 are discontinuous. In these levels a pulse is issued only when the output is under target, and each level uses a longer fixed on-time than the one below it. Level 3 is continuous conduction. In level 3 a pulse runs every period with a nominal on-time, which is lengthened or shortened for one period when a window border was crossed. Repeated trips of the upper border in level 3 drop the controller back to level 2. The period comes either from a free-running divider of the block clock or from a count of rising edges on an external sync input. A shutdown input forces both drives off at once.

Top module: `boost_ctrl`

## Requirements
- R1: While reset is held, `lo_en_o`, `rect_en_o` and `level_chg_o` are low and `level_o` is 0.
- R2: In levels 0, 1 and 2 (`level_o` = 0, 1, 2), a pulse starts at a period start only if `uv_i` is high at that start. Its low-side interval lasts ON_UNIT shifted left by the level (4, 8 or 16 cycles), and its rectifier interval has the same length. With `uv_i` low, no pulse is issued.
- R3: In levels 0 to 2, `win_lo_i` high during a pulse's decision cycle raises the level by one, and 2 goes to 3. The level never changes in a period that has no pulse.
- R4: In level 3, a pulse runs every period whatever `uv_i` is. With no border flag, the low-side interval is CCM_NOM (24) cycles and the rectifier interval is always RECT_CCM (24) cycles.
- R5: In level 3, `win_lo_i` at a decision makes the next on-time CCM_NOM+CCM_BOOST (64) cycles. `win_lo_i` takes priority over `win_hi_i`.
- R6: In level 3, `win_hi_i` at a decision makes the next on-time CCM_NOM-CCM_CUT (8) cycles. After HI_LIMIT (3) consecutive decisions with `win_hi_i`, the level drops to 2. A decision without `win_hi_i` clears the run.
- R7: While `ilim_i` is high, `lo_en_o` is low in that same cycle and the on interval ends. The rectifier interval that follows keeps its full length.
- R8: `lo_en_o` and `rect_en_o` are never high together, and at least one cycle with both low separates them.
- R9: While `shdn_i` is high, both enables are low in that same cycle. The level returns to 0 on the next edge and stays there.
- R10: `level_chg_o` is high for exactly one cycle after each level change, and low otherwise.
- R11: With `sync_en_i` high, a period starts only on every SYNC_DIV-th (65th) rising edge of `sync_i`. The internal divider then starts nothing.
- R12: With `sync_en_i` low, a period starts every PERIOD_CYC (100) clock cycles, the first on the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Time-base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shdn_i | input | 1 | Shutdown, forces both drives off |
| sync_en_i | input | 1 | Select the external sync input as the period source |
| sync_i | input | 1 | External sync clock, asynchronous |
| uv_i | input | 1 | Output below regulation target |
| win_lo_i | input | 1 | Output below lower window border |
| win_hi_i | input | 1 | Output above upper window border |
| ilim_i | input | 1 | Inductor current at limit |
| lo_en_o | output | 1 | Low-side switch enable |
| rect_en_o | output | 1 | Synchronous rectifier enable |
| level_o | output | 2 | Operating level, 0 to 2 discontinuous, 3 continuous |
| level_chg_o | output | 1 | One-cycle pulse on a level change |

## Verification
The assertions assume that `shdn_i` and `ilim_i` are synchronous to `clk_i`, because both gate the drive outputs in the same cycle. They also assume that the window flags are stable around the decision cycle. The stimulus changes flags only on falling clock edges, and only just before a period start. A whole period therefore sees one flag set, and each table row maps to exactly one pulse or none. `sync_i` is toggled with two-cycle phases, so the two-stage synchroniser never misses an edge.

// File: rtl/boost_pkg.sv
package boost_pkg;
  localparam int unsigned LVL_W      = 2;
  localparam int unsigned DCM_LEVELS = 3;

  typedef logic [LVL_W-1:0] level_t;
  localparam level_t LVL_CCM = level_t'(DCM_LEVELS);

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ON,
    SEQ_GAP_A,
    SEQ_RECT,
    SEQ_GAP_B,
    SEQ_EVAL
  } seq_state_e;
endpackage

// File: rtl/boost_tick_gen.sv
module boost_tick_gen #(
  parameter int unsigned PERIOD_CYC  = 100,
  parameter int unsigned SYNC_DIV    = 65,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_en_i,
  input  logic sync_i,
  output logic tick_o
);
  localparam int unsigned PCNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam int unsigned ECNT_W = (SYNC_DIV > 1) ? $clog2(SYNC_DIV) : 1;

  logic [PCNT_W-1:0]      pcnt_q;
  logic [ECNT_W-1:0]      ecnt_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_prev_q;
  logic                   sync_rise;
  logic                   sync_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
    end else if (pcnt_q == PCNT_W'(PERIOD_CYC - 1)) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + PCNT_W'(1);
    end
  end

  // resynchronise the external clock before edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q      <= '0;
      sync_prev_q <= 1'b0;
    end else begin
      sync_q      <= {sync_q[SYNC_STAGES-2:0], sync_i};
      sync_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign sync_rise = sync_q[SYNC_STAGES-1] & ~sync_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecnt_q <= '0;
    end else if (sync_rise) begin
      if (ecnt_q == ECNT_W'(SYNC_DIV - 1)) ecnt_q <= '0;
      else                                 ecnt_q <= ecnt_q + ECNT_W'(1);
    end
  end

  assign sync_tick = sync_rise && (ecnt_q == ECNT_W'(SYNC_DIV - 1));
  assign tick_o    = sync_en_i ? sync_tick : (pcnt_q == '0);
endmodule

// File: rtl/boost_level_fsm.sv
module boost_level_fsm
  import boost_pkg::*;
#(
  parameter int unsigned LEN_W     = 7,
  parameter int unsigned ON_UNIT   = 4,
  parameter int unsigned CCM_NOM   = 24,
  parameter int unsigned CCM_BOOST = 40,
  parameter int unsigned CCM_CUT   = 16,
  parameter int unsigned RECT_CCM  = 24,
  parameter int unsigned HI_LIMIT  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shdn_i,
  input  logic             uv_i,
  input  logic             win_lo_i,
  input  logic             win_hi_i,
  input  logic             eval_i,
  output level_t           level_o,
  output logic             level_chg_o,
  output logic             req_o,
  output logic [LEN_W-1:0] on_len_o,
  output logic [LEN_W-1:0] rect_len_o
);
  localparam int unsigned HI_W = $clog2(HI_LIMIT + 1);
  localparam logic [LEN_W-1:0] ON_NOM     = LEN_W'(CCM_NOM);
  localparam logic [LEN_W-1:0] ON_STRETCH = LEN_W'(CCM_NOM + CCM_BOOST);
  localparam logic [LEN_W-1:0] ON_SHORT   = LEN_W'(CCM_NOM - CCM_CUT);
  localparam logic [LEN_W-1:0] RECT_FIX   = LEN_W'(RECT_CCM);

  level_t           level_q, level_d;
  logic [LEN_W-1:0] next_on_q, next_on_d;
  logic [HI_W-1:0]  hi_cnt_q, hi_cnt_d;
  logic             chg_q;
  logic [LEN_W-1:0] on_tab [2**LVL_W];

  // on-time per level: shifted unit in the ladder, live value in continuous mode
  for (genvar k = 0; k < 2**LVL_W; k++) begin : g_on_tab
    if (k < DCM_LEVELS) begin : g_dcm
      assign on_tab[k] = LEN_W'(ON_UNIT << k);
    end else begin : g_ccm
      assign on_tab[k] = next_on_q;
    end
  end

  always_comb begin
    level_d   = level_q;
    next_on_d = next_on_q;
    hi_cnt_d  = hi_cnt_q;
    if (shdn_i) begin
      level_d   = '0;
      next_on_d = ON_NOM;
      hi_cnt_d  = '0;
    end else if (eval_i) begin
      if (level_q != LVL_CCM) begin
        if (win_lo_i) begin
          level_d   = level_q + level_t'(1);
          next_on_d = ON_NOM;
          hi_cnt_d  = '0;
        end
      end else if (win_lo_i) begin
        next_on_d = ON_STRETCH;
        hi_cnt_d  = '0;
      end else if (win_hi_i) begin
        if (hi_cnt_q == HI_W'(HI_LIMIT - 1)) begin
          level_d   = LVL_CCM - level_t'(1);
          next_on_d = ON_NOM;
          hi_cnt_d  = '0;
        end else begin
          next_on_d = ON_SHORT;
          hi_cnt_d  = hi_cnt_q + HI_W'(1);
        end
      end else begin
        next_on_d = ON_NOM;
        hi_cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q   <= '0;
      next_on_q <= ON_NOM;
      hi_cnt_q  <= '0;
      chg_q     <= 1'b0;
    end else begin
      level_q   <= level_d;
      next_on_q <= next_on_d;
      hi_cnt_q  <= hi_cnt_d;
      chg_q     <= (level_d != level_q);
    end
  end

  assign level_o     = level_q;
  assign level_chg_o = chg_q;
  assign req_o       = (level_q == LVL_CCM) || uv_i;
  assign on_len_o    = on_tab[level_q];
  assign rect_len_o  = (level_q == LVL_CCM) ? RECT_FIX : on_tab[level_q];
endmodule

// File: rtl/boost_seq.sv
module boost_seq
  import boost_pkg::*;
#(
  parameter int unsigned LEN_W    = 7,
  parameter int unsigned DEAD_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shdn_i,
  input  logic             tick_i,
  input  logic             req_i,
  input  logic             ilim_i,
  input  logic [LEN_W-1:0] on_len_i,
  input  logic [LEN_W-1:0] rect_len_i,
  output logic             lo_en_o,
  output logic             rect_en_o,
  output logic             eval_o
);
  localparam logic [LEN_W-1:0] GAP_LAST = LEN_W'(DEAD_CYC - 1);

  seq_state_e       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] rect_len_q;
  logic             cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      rect_len_q <= '0;
    end else if (shdn_i) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (tick_i && req_i) begin
            state_q    <= SEQ_ON;
            cnt_q      <= on_len_i - LEN_W'(1);
            rect_len_q <= rect_len_i;
          end
        end
        SEQ_ON: begin
          if (ilim_i || cnt_done) begin
            state_q <= SEQ_GAP_A;
            cnt_q   <= GAP_LAST;
          end else begin
            cnt_q <= cnt_q - LEN_W'(1);
          end
        end
        SEQ_GAP_A: begin
          if (cnt_done) begin
            state_q <= SEQ_RECT;
            cnt_q   <= rect_len_q - LEN_W'(1);
          end else begin
            cnt_q <= cnt_q - LEN_W'(1);
          end
        end
        SEQ_RECT: begin
          if (cnt_done) begin
            state_q <= SEQ_GAP_B;
            cnt_q   <= GAP_LAST;
          end else begin
            cnt_q <= cnt_q - LEN_W'(1);
          end
        end
        SEQ_GAP_B: begin
          if (cnt_done) state_q <= SEQ_EVAL;
          else          cnt_q   <= cnt_q - LEN_W'(1);
        end
        SEQ_EVAL: state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  // current limit and shutdown cut the drives without waiting for an edge
  assign lo_en_o   = (state_q == SEQ_ON) && !ilim_i && !shdn_i;
  assign rect_en_o = (state_q == SEQ_RECT) && !shdn_i;
  assign eval_o    = (state_q == SEQ_EVAL);
endmodule

// File: rtl/boost_ctrl.sv
module boost_ctrl
  import boost_pkg::*;
#(
  parameter int unsigned PERIOD_CYC  = 100,
  parameter int unsigned SYNC_DIV    = 65,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEAD_CYC    = 1,
  parameter int unsigned ON_UNIT     = 4,
  parameter int unsigned CCM_NOM     = 24,
  parameter int unsigned CCM_BOOST   = 40,
  parameter int unsigned CCM_CUT     = 16,
  parameter int unsigned RECT_CCM    = 24,
  parameter int unsigned HI_LIMIT    = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shdn_i,
  input  logic       sync_en_i,
  input  logic       sync_i,
  input  logic       uv_i,
  input  logic       win_lo_i,
  input  logic       win_hi_i,
  input  logic       ilim_i,
  output logic       lo_en_o,
  output logic       rect_en_o,
  output logic [1:0] level_o,
  output logic       level_chg_o
);
  localparam int unsigned LEN_W = $clog2(PERIOD_CYC + 1);

  logic             tick;
  logic             req;
  logic             eval;
  logic [LEN_W-1:0] on_len;
  logic [LEN_W-1:0] rect_len;

  boost_tick_gen #(
    .PERIOD_CYC (PERIOD_CYC),
    .SYNC_DIV   (SYNC_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_en_i(sync_en_i),
    .sync_i   (sync_i),
    .tick_o   (tick)
  );

  boost_level_fsm #(
    .LEN_W    (LEN_W),
    .ON_UNIT  (ON_UNIT),
    .CCM_NOM  (CCM_NOM),
    .CCM_BOOST(CCM_BOOST),
    .CCM_CUT  (CCM_CUT),
    .RECT_CCM (RECT_CCM),
    .HI_LIMIT (HI_LIMIT)
  ) u_level (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shdn_i     (shdn_i),
    .uv_i       (uv_i),
    .win_lo_i   (win_lo_i),
    .win_hi_i   (win_hi_i),
    .eval_i     (eval),
    .level_o    (level_o),
    .level_chg_o(level_chg_o),
    .req_o      (req),
    .on_len_o   (on_len),
    .rect_len_o (rect_len)
  );

  boost_seq #(
    .LEN_W   (LEN_W),
    .DEAD_CYC(DEAD_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shdn_i    (shdn_i),
    .tick_i    (tick),
    .req_i     (req),
    .ilim_i    (ilim_i),
    .on_len_i  (on_len),
    .rect_len_i(rect_len),
    .lo_en_o   (lo_en_o),
    .rect_en_o (rect_en_o),
    .eval_o    (eval)
  );
endmodule

// File: rtl/boost_ctrl_chk.sv
module boost_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       shdn_i,
  input logic       ilim_i,
  input logic       lo_en_o,
  input logic       rect_en_o,
  input logic [1:0] level_o,
  input logic       level_chg_o
);
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lo_en_o && rect_en_o));

  p_gap_lo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_en_o |=> !rect_en_o);

  p_gap_rect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rect_en_o |=> !lo_en_o);

  p_ilim_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_i |-> !lo_en_o);

  p_shdn_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |-> (!lo_en_o && !rect_en_o));

  p_shdn_lvl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> (level_o == 2'd0));

  p_chg_mark_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_chg_o |-> (level_o != $past(level_o)));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_chg_o |-> (level_o == $past(level_o)));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_chg_o && !$past(shdn_i)) |->
      ((level_o == $past(level_o) + 2'd1) || (level_o == $past(level_o) - 2'd1)));
endmodule

bind boost_ctrl boost_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shdn_i     (shdn_i),
  .ilim_i     (ilim_i),
  .lo_en_o    (lo_en_o),
  .rect_en_o  (rect_en_o),
  .level_o    (level_o),
  .level_chg_o(level_chg_o)
);

// File: tb/tb_boost_ctrl.sv
module tb_boost_ctrl;
  localparam int PERIOD = 100;
  localparam int NV     = 23;
  // {uv, win_lo, win_hi, ilim, exp_lo_cycles, exp_rect_cycles, exp_level, exp_chg_pulses}
  localparam logic [23:0] VEC [NV] = '{
    {4'b0000, 8'd0,  8'd0,  2'd0, 2'd0},  // R2 no demand, no pulse
    {4'b1000, 8'd4,  8'd4,  2'd0, 2'd0},  // R2 level 0 pulse
    {4'b1100, 8'd4,  8'd4,  2'd1, 2'd1},  // R3 climb to 1
    {4'b1000, 8'd8,  8'd8,  2'd1, 2'd0},  // R2 level 1 pulse
    {4'b0100, 8'd0,  8'd0,  2'd1, 2'd0},  // R3 no pulse, no climb
    {4'b1100, 8'd8,  8'd8,  2'd2, 2'd1},  // R3 climb to 2
    {4'b1001, 8'd0,  8'd16, 2'd2, 2'd0},  // R7 limit in ladder
    {4'b1100, 8'd16, 8'd16, 2'd3, 2'd1},  // R3 enter continuous
    {4'b0000, 8'd24, 8'd24, 2'd3, 2'd0},  // R4 nominal
    {4'b0100, 8'd24, 8'd24, 2'd3, 2'd0},  // R5 low border seen
    {4'b0000, 8'd64, 8'd24, 2'd3, 2'd0},  // R5 stretched on-time
    {4'b0010, 8'd24, 8'd24, 2'd3, 2'd0},  // R6 high border 1
    {4'b0000, 8'd8,  8'd24, 2'd3, 2'd0},  // R6 short, run cleared
    {4'b0010, 8'd24, 8'd24, 2'd3, 2'd0},  // R6 run 1
    {4'b0010, 8'd8,  8'd24, 2'd3, 2'd0},  // R6 run 2
    {4'b0010, 8'd8,  8'd24, 2'd2, 2'd1},  // R6 run 3, step down
    {4'b1000, 8'd16, 8'd16, 2'd2, 2'd0},  // R2 level 2 pulse
    {4'b0000, 8'd0,  8'd0,  2'd2, 2'd0},  // R2 no demand
    {4'b1100, 8'd16, 8'd16, 2'd3, 2'd1},  // R3 re-enter continuous
    {4'b0001, 8'd0,  8'd24, 2'd3, 2'd0},  // R7 limit in continuous
    {4'b0000, 8'd24, 8'd24, 2'd3, 2'd0},  // R4 nominal
    {4'b0110, 8'd24, 8'd24, 2'd3, 2'd0},  // R5 low wins over high
    {4'b0000, 8'd64, 8'd24, 2'd3, 2'd0}   // R5 stretched
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       shdn_i = 1'b0;
  logic       sync_en_i = 1'b0;
  logic       sync_i = 1'b0;
  logic       uv_i = 1'b0;
  logic       win_lo_i = 1'b0;
  logic       win_hi_i = 1'b0;
  logic       ilim_i = 1'b0;
  logic       lo_en_o;
  logic       rect_en_o;
  logic [1:0] level_o;
  logic       level_chg_o;

  int  checks = 0;
  int  failures = 0;
  int  dead_viol = 0;
  bit  done = 1'b0;
  logic prev_lo = 1'b0;
  logic prev_rect = 1'b0;

  always #4 clk_i = ~clk_i;

  boost_ctrl dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shdn_i     (shdn_i),
    .sync_en_i  (sync_en_i),
    .sync_i     (sync_i),
    .uv_i       (uv_i),
    .win_lo_i   (win_lo_i),
    .win_hi_i   (win_hi_i),
    .ilim_i     (ilim_i),
    .lo_en_o    (lo_en_o),
    .rect_en_o  (rect_en_o),
    .level_o    (level_o),
    .level_chg_o(level_chg_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sample(inout int lo_c, inout int rect_c, inout int chg_c, inout int rise_c);
    @(posedge clk_i);
    @(negedge clk_i);
    if (lo_en_o && rect_en_o) dead_viol++;
    if ((prev_lo && rect_en_o) || (prev_rect && lo_en_o)) dead_viol++;
    if (lo_en_o && !prev_lo) rise_c++;
    lo_c   += int'(lo_en_o);
    rect_c += int'(rect_en_o);
    chg_c  += int'(level_chg_o);
    prev_lo   = lo_en_o;
    prev_rect = rect_en_o;
  endtask

  task automatic window(input int n, output int lo_c, output int rect_c,
                        output int chg_c, output int rise_c);
    lo_c = 0; rect_c = 0; chg_c = 0; rise_c = 0;
    for (int k = 0; k < n; k++) sample(lo_c, rect_c, chg_c, rise_c);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lo_c, rect_c, chg_c, rise_c;
    int lvl_prev;
    logic [23:0] row;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(lo_en_o == 1'b0,    "R1 lo_en", int'(lo_en_o), 0);
    chk(rect_en_o == 1'b0,  "R1 rect_en", int'(rect_en_o), 0);
    chk(level_o == 2'd0,    "R1 level", int'(level_o), 0);
    chk(level_chg_o == 1'b0, "R1 chg", int'(level_chg_o), 0);

    // one table row per switching period; flags change just before the period start
    rst_ni = 1'b1;
    lvl_prev = 0;
    for (int i = 0; i < NV; i++) begin
      row = VEC[i];
      uv_i = row[23]; win_lo_i = row[22]; win_hi_i = row[21]; ilim_i = row[20];
      window(PERIOD, lo_c, rect_c, chg_c, rise_c);
      chk(lo_c == int'(row[19:12]),
          row[20] ? "R7 lo cycles" : (lvl_prev == 3 ? "R5 lo cycles" : "R2 lo cycles"),
          lo_c, int'(row[19:12]));
      chk(rect_c == int'(row[11:4]), lvl_prev == 3 ? "R4 rect cycles" : "R2 rect cycles",
          rect_c, int'(row[11:4]));
      chk(int'(level_o) == int'(row[3:2]), lvl_prev == 3 ? "R6 level" : "R3 level",
          int'(level_o), int'(row[3:2]));
      chk(chg_c == int'(row[1:0]), "R10 chg pulses", chg_c, int'(row[1:0]));
      lvl_prev = int'(row[3:2]);
    end
    uv_i = 1'b0; win_lo_i = 1'b0; win_hi_i = 1'b0; ilim_i = 1'b0;

    // R12 one start per internal period in continuous mode
    window(3 * PERIOD, lo_c, rect_c, chg_c, rise_c);
    chk(rise_c == 3, "R12 pulse starts", rise_c, 3);
    chk(lo_c == 72, "R12 lo cycles", lo_c, 72);
    chk(dead_viol == 0, "R8 overlap or no gap", dead_viol, 0);

    // R9 shutdown during an on interval
    @(posedge clk_i);
    @(negedge clk_i);
    chk(lo_en_o == 1'b1, "R4 on at period start", int'(lo_en_o), 1);
    shdn_i = 1'b1;
    #1;
    chk(lo_en_o == 1'b0 && rect_en_o == 1'b0, "R9 drives off at once",
        int'({lo_en_o, rect_en_o}), 0);
    prev_lo = 1'b0;
    uv_i = 1'b1;
    window(2 * PERIOD, lo_c, rect_c, chg_c, rise_c);
    chk(lo_c + rect_c == 0, "R9 drives held off", lo_c + rect_c, 0);
    chk(level_o == 2'd0, "R9 level reset", int'(level_o), 0);
    chk(chg_c == 1, "R10 chg on shutdown", chg_c, 1);
    shdn_i = 1'b0;
    uv_i = 1'b0;
    window(2 * PERIOD, lo_c, rect_c, chg_c, rise_c);
    chk(lo_c == 0, "R2 no demand after shutdown", lo_c, 0);

    // R11 external sync
    rst_ni = 1'b0;
    sync_en_i = 1'b1;
    uv_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    window(3 * PERIOD, lo_c, rect_c, chg_c, rise_c);
    chk(lo_c == 0, "R11 no internal start", lo_c, 0);
    lo_c = 0; rect_c = 0; chg_c = 0; rise_c = 0;
    for (int e = 0; e < 65; e++) begin
      sync_i = 1'b1;
      sample(lo_c, rect_c, chg_c, rise_c);
      sample(lo_c, rect_c, chg_c, rise_c);
      if (e == 63) chk(lo_c == 0, "R11 early start", lo_c, 0);
      sync_i = 1'b0;
      sample(lo_c, rect_c, chg_c, rise_c);
      sample(lo_c, rect_c, chg_c, rise_c);
    end
    for (int k = 0; k < PERIOD; k++) sample(lo_c, rect_c, chg_c, rise_c);
    chk(lo_c == 4, "R11 one pulse per sync count", lo_c, 4);
    chk(dead_viol == 0, "R8 overlap or no gap", dead_viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule